// File: doc/BRIEF.md
# Four-Channel Memory DMA Engine

This block copies blocks of halfwords or words from one address range to another without processor involvement. It has four independent channels. Each channel holds a programmed source address, destination address, unit count and control word. Each unit is moved as one read on a shared memory master port, followed by one write of the same data.

A channel is armed when its enable bit goes from 0 to 1. At that point the programmed values are copied into working registers. The channel then starts at once, or waits for a horizontal-blank or vertical-blank pulse, depending on its timing field. After a run, a channel either disarms itself or re-arms for the next pulse with its count reloaded. When enabled, each channel raises its own single-cycle completion interrupt.

When several channels are waiting, the lowest-numbered one goes first. Each run finishes completely before another channel is granted.

Top module: `dma4_engine`

## Requirements
- R1: After reset, every readable register of every channel reads 0, `mem_req` is 0 and `irq` is 0.
- R2: A write to the source or destination register (selector 0 or 1) stores the value with bit 0 cleared. When control bit 3 (word mode) is set, bits 1:0 of both working addresses are forced to 0 when the run begins.
- R3: A programmed count of 0 (selector 2) means 0x10000 units on channel 3 and 0x4000 units on channels 0 to 2.
- R4: A control write (selector 3) that takes bit 0 (enable) from 0 to 1 loads the working source, destination and count. With timing field bits 5:4 = 0 (immediate), the run then starts. A control write while the channel is already enabled reloads nothing.
- R5: A `hblank_pulse` starts every enabled channel whose timing is 2. A `vblank_pulse` starts every enabled channel whose timing is 1. A pulse does not start channels with any other timing.
- R6: The source control field (bits 7:6) and the destination control field (bits 9:8) each select how the address steps after each unit: 0 adds one unit, 1 subtracts one unit, 2 holds the address, and 3 adds one unit with reload. A unit is 2 bytes in halfword mode and 4 bytes in word mode.
- R7: When a run ends with bit 2 (repeat) clear, the channel clears its enable bit in the readable control register.
- R8: When a run ends with repeat set, the enable bit stays set and the working count is reloaded. The working destination is reloaded from the programmed one only when the destination control is 3. The source continues from where it stopped.
- R9: When a run ends and control bit 1 (interrupt enable) is set, that channel's `irq` bit pulses once. When bit 1 is clear, `irq` stays low.
- R10: When several channels wait at once, the lowest-numbered channel is served first, and its whole run completes before any other channel's access.
- R11: Timing value 3 is stored but never starts a transfer, including on channel 0.
- R12: Each unit is a read request (`mem_we`=0) followed by a write request (`mem_we`=1). The write carries the data that was read. `mem_size`=1 marks a word access. A request holds its address and direction until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_ch | input | 2 | Channel addressed by a write |
| cfg_sel | input | 2 | Register: 0 source, 1 destination, 2 count, 3 control |
| cfg_wdata | input | 32 | Write data |
| rd_ch | input | 2 | Channel addressed by readback |
| rd_sel | input | 2 | Register selected for readback |
| rd_data | output | 32 | Readback data |
| hblank_pulse | input | 1 | Horizontal-blank trigger |
| vblank_pulse | input | 1 | Vertical-blank trigger |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_size | output | 1 | 1 = word, 0 = halfword |
| mem_addr | output | 32 | Byte address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data |
| mem_ack | input | 1 | Request accepted |
| irq | output | 4 | Per-channel completion pulse |

## Verification
The bench targets the following corner cases:

- **Zero count.** A design that treated a zero count as zero units would issue no accesses. One that ignored the channel number would move 0x4000 units on channel 3 instead of 0x10000.
- **Repeat reload.** This separates a destination that reloads from one that keeps stepping, with a source rewritten between pulses. A design that reloaded on any control write, or reset the source on repeat, would show wrong addresses on the second run.
- **Collision of two channels on one blank pulse.** An arbiter that interleaved the two channels, or picked the higher-numbered one first, breaks the expected access order.
- **Unaligned word addresses and downward stepping.** A design that forgot the low-bit masking would issue misaligned word addresses.
- **Memory stalls.** Randomly spaced stalls check that an address or direction changing before acknowledge is caught.

// File: rtl/dma4_pkg.sv
package dma4_pkg;
  localparam int ADDR_W  = 32;
  localparam int CNT_W   = 16;
  localparam int WCNT_W  = CNT_W + 1;
  localparam int CTRL_W  = 10;

  typedef enum logic [1:0] {TM_NOW = 2'd0, TM_VBL = 2'd1, TM_HBL = 2'd2, TM_SPECIAL = 2'd3} trig_e;
  typedef enum logic [1:0] {ST_INC = 2'd0, ST_DEC = 2'd1, ST_HOLD = 2'd2, ST_INC_RLD = 2'd3} step_e;
  typedef enum logic [1:0] {MV_IDLE = 2'd0, MV_RD = 2'd1, MV_WR = 2'd2} mv_e;

  typedef struct packed {
    logic [1:0] dst_ctl;
    logic [1:0] src_ctl;
    logic [1:0] timing;
    logic       word;
    logic       rpt;
    logic       irq_en;
    logic       en;
  } ctrl_t;

  // Signed step expressed modulo 2^ADDR_W.
  function automatic logic [ADDR_W-1:0] step_delta(input logic [1:0] ctl, input logic word);
    logic [ADDR_W-1:0] unit;
    unit = word ? ADDR_W'(4) : ADDR_W'(2);
    case (ctl)
      ST_DEC:  step_delta = ~unit + ADDR_W'(1);
      ST_HOLD: step_delta = '0;
      default: step_delta = unit;
    endcase
  endfunction

  // Zero count selects the channel-dependent maximum.
  function automatic logic [WCNT_W-1:0] eff_count(input logic [CNT_W-1:0] raw, input logic big);
    if (raw != '0)  eff_count = {1'b0, raw};
    else if (big)   eff_count = WCNT_W'(1) << CNT_W;
    else            eff_count = WCNT_W'(1) << (CNT_W - 2);
  endfunction
endpackage

// File: rtl/dma4_channel.sv
module dma4_channel
  import dma4_pkg::*;
#(
  parameter bit BIG_COUNT = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [31:0]       wr_data,
  input  logic              hblank,
  input  logic              vblank,
  input  logic              grant,
  input  logic              adv,
  output logic              pending,
  output logic [ADDR_W-1:0] cur_src,
  output logic [ADDR_W-1:0] cur_dst,
  output logic              word,
  output logic              last_unit,
  output logic              irq,
  output logic [ADDR_W-1:0] rd_src,
  output logic [ADDR_W-1:0] rd_dst,
  output logic [CNT_W-1:0]  rd_cnt,
  output logic [CTRL_W-1:0] rd_ctrl
);
  logic [ADDR_W-1:0] src_q, dst_q, wsrc_q, wdst_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [WCNT_W-1:0] wcnt_q;
  ctrl_t             ctrl_q, new_ctrl;
  logic              pend_q, irq_q;
  logic              wr_ctrl, en_rise, en_drop, finish, trig;

  assign new_ctrl = ctrl_t'(wr_data[CTRL_W-1:0]);
  assign wr_ctrl  = wr_en && (wr_sel == 2'd3);
  assign en_rise  = wr_ctrl && new_ctrl.en && !ctrl_q.en;
  assign en_drop  = wr_ctrl && !new_ctrl.en;
  assign last_unit = (wcnt_q == WCNT_W'(1));
  assign finish   = adv && last_unit;
  assign trig     = (en_rise && new_ctrl.timing == TM_NOW)
                 || (hblank && ctrl_q.en && ctrl_q.timing == TM_HBL)
                 || (vblank && ctrl_q.en && ctrl_q.timing == TM_VBL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= '0; dst_q <= '0; cnt_q <= '0; ctrl_q <= '0;
    end else begin
      if (wr_en && wr_sel == 2'd0) src_q <= {wr_data[ADDR_W-1:1], 1'b0};
      if (wr_en && wr_sel == 2'd1) dst_q <= {wr_data[ADDR_W-1:1], 1'b0};
      if (wr_en && wr_sel == 2'd2) cnt_q <= wr_data[CNT_W-1:0];
      if (wr_ctrl)                 ctrl_q <= new_ctrl;
      else if (finish && !ctrl_q.rpt) ctrl_q.en <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wsrc_q <= '0; wdst_q <= '0; wcnt_q <= '0;
    end else if (en_rise) begin
      wsrc_q <= src_q;
      wdst_q <= dst_q;
      wcnt_q <= eff_count(cnt_q, BIG_COUNT);
    end else if (grant && ctrl_q.word) begin
      wsrc_q[1:0] <= 2'b00;
      wdst_q[1:0] <= 2'b00;
    end else if (adv) begin
      wsrc_q <= wsrc_q + step_delta(ctrl_q.src_ctl, ctrl_q.word);
      wdst_q <= wdst_q + step_delta(ctrl_q.dst_ctl, ctrl_q.word);
      wcnt_q <= wcnt_q - WCNT_W'(1);
      if (finish && ctrl_q.rpt) begin
        wcnt_q <= eff_count(cnt_q, BIG_COUNT);
        if (ctrl_q.dst_ctl == ST_INC_RLD) wdst_q <= dst_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0; irq_q <= 1'b0;
    end else begin
      pend_q <= ((pend_q && !grant) || trig) && !en_drop && !(finish && !ctrl_q.rpt);
      irq_q  <= finish && ctrl_q.irq_en;
    end
  end

  assign pending = pend_q;
  assign cur_src = wsrc_q;
  assign cur_dst = wdst_q;
  assign word    = ctrl_q.word;
  assign irq     = irq_q;
  assign rd_src  = src_q;
  assign rd_dst  = dst_q;
  assign rd_cnt  = cnt_q;
  assign rd_ctrl = ctrl_q;

  // R4: an immediate arm leaves the channel waiting for service
  a_r4_now_arms: assert property (@(posedge clk) disable iff (!rst_n)
    (en_rise && new_ctrl.timing == TM_NOW) |=> pend_q);
  // R7: a one-shot finish drops the enable bit
  a_r7_enable_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (finish && !ctrl_q.rpt && !wr_ctrl) |=> !ctrl_q.en);
  // R9: no interrupt when the enable for it is clear
  a_r9_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (finish && !ctrl_q.irq_en) |=> !irq_q);
  // R11: special timing never raises a request
  a_r11_special_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.timing == TM_SPECIAL && !pend_q && !wr_ctrl) |=> !pend_q);
endmodule

// File: rtl/dma4_arbiter.sv
module dma4_arbiter #(
  parameter int NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              idle,
  input  logic [NUM_CH-1:0] pend,
  output logic [NUM_CH-1:0] grant
);
  logic taken;

  always_comb begin
    grant = '0;
    taken = 1'b0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (idle && pend[i] && !taken) begin
        grant[i] = 1'b1;
        taken    = 1'b1;
      end
    end
  end

  // R10: at most one grant, never passing over a lower waiting channel
  a_r10_single_grant: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(grant));

  for (genvar g = 1; g < NUM_CH; g++) begin : g_prio
    a_r10_lowest_first: assert property (@(posedge clk) disable iff (!rst_n)
      grant[g] |-> (pend[g-1:0] == '0));
  end
endmodule

// File: rtl/dma4_mover.sv
module dma4_mover
  import dma4_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] src_addr,
  input  logic [ADDR_W-1:0] dst_addr,
  input  logic              word,
  input  logic              last_unit,
  output logic              idle,
  output logic              adv,
  output logic              mem_req,
  output logic              mem_we,
  output logic              mem_size,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata,
  input  logic              mem_ack
);
  mv_e         state_q;
  logic [31:0] buf_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= MV_IDLE;
      buf_q   <= '0;
    end else begin
      case (state_q)
        MV_IDLE: if (start) state_q <= MV_RD;
        MV_RD: if (mem_ack) begin
          buf_q   <= mem_rdata;
          state_q <= MV_WR;
        end
        MV_WR: if (mem_ack) state_q <= last_unit ? MV_IDLE : MV_RD;
        default: state_q <= MV_IDLE;
      endcase
    end
  end

  assign idle      = (state_q == MV_IDLE);
  assign adv       = (state_q == MV_WR) && mem_ack;
  assign mem_req   = (state_q != MV_IDLE);
  assign mem_we    = (state_q == MV_WR);
  assign mem_size  = word;
  assign mem_addr  = (state_q == MV_WR) ? dst_addr : src_addr;
  assign mem_wdata = buf_q;

  // R12: request held steady until accepted
  a_r12_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
  // R12: an accepted read is followed by a write
  a_r12_read_then_write: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we && mem_ack) |=> (mem_req && mem_we));
  // R2: word accesses are aligned
  a_r2_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_size) |-> (mem_addr[1:0] == 2'b00));
endmodule

// File: rtl/dma4_engine.sv
module dma4_engine
  import dma4_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfg_we,
  input  logic [$clog2(NUM_CH)-1:0]  cfg_ch,
  input  logic [1:0]                 cfg_sel,
  input  logic [31:0]                cfg_wdata,
  input  logic [$clog2(NUM_CH)-1:0]  rd_ch,
  input  logic [1:0]                 rd_sel,
  output logic [31:0]                rd_data,
  input  logic                       hblank_pulse,
  input  logic                       vblank_pulse,
  output logic                       mem_req,
  output logic                       mem_we,
  output logic                       mem_size,
  output logic [31:0]                mem_addr,
  output logic [31:0]                mem_wdata,
  input  logic [31:0]                mem_rdata,
  input  logic                       mem_ack,
  output logic [NUM_CH-1:0]          irq
);
  localparam int CH_W = $clog2(NUM_CH);

  logic [NUM_CH-1:0] pend, grant, ch_word, ch_last, ch_adv;
  logic [ADDR_W-1:0] ch_src [NUM_CH];
  logic [ADDR_W-1:0] ch_dst [NUM_CH];
  logic [ADDR_W-1:0] r_src  [NUM_CH];
  logic [ADDR_W-1:0] r_dst  [NUM_CH];
  logic [CNT_W-1:0]  r_cnt  [NUM_CH];
  logic [CTRL_W-1:0] r_ctrl [NUM_CH];
  logic [CH_W-1:0]   sel_q, gidx;
  logic              idle, adv;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    assign ch_adv[i] = adv && (sel_q == CH_W'(i));
    dma4_channel #(.BIG_COUNT(i == NUM_CH - 1)) u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (cfg_we && cfg_ch == CH_W'(i)),
      .wr_sel   (cfg_sel),
      .wr_data  (cfg_wdata),
      .hblank   (hblank_pulse),
      .vblank   (vblank_pulse),
      .grant    (grant[i]),
      .adv      (ch_adv[i]),
      .pending  (pend[i]),
      .cur_src  (ch_src[i]),
      .cur_dst  (ch_dst[i]),
      .word     (ch_word[i]),
      .last_unit(ch_last[i]),
      .irq      (irq[i]),
      .rd_src   (r_src[i]),
      .rd_dst   (r_dst[i]),
      .rd_cnt   (r_cnt[i]),
      .rd_ctrl  (r_ctrl[i])
    );
  end

  dma4_arbiter #(.NUM_CH(NUM_CH)) u_arb (
    .clk  (clk),
    .rst_n(rst_n),
    .idle (idle),
    .pend (pend),
    .grant(grant)
  );

  always_comb begin
    gidx = '0;
    for (int i = 0; i < NUM_CH; i++) if (grant[i]) gidx = CH_W'(i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sel_q <= '0;
    else if (|grant) sel_q <= gidx;
  end

  dma4_mover u_mv (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (|grant),
    .src_addr (ch_src[sel_q]),
    .dst_addr (ch_dst[sel_q]),
    .word     (ch_word[sel_q]),
    .last_unit(ch_last[sel_q]),
    .idle     (idle),
    .adv      (adv),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .mem_size (mem_size),
    .mem_addr (mem_addr),
    .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata),
    .mem_ack  (mem_ack)
  );

  always_comb begin
    case (rd_sel)
      2'd0:    rd_data = r_src[rd_ch];
      2'd1:    rd_data = r_dst[rd_ch];
      2'd2:    rd_data = 32'(r_cnt[rd_ch]);
      default: rd_data = 32'(r_ctrl[rd_ch]);
    endcase
  end

  // R10: the serving channel does not change while the mover is busy
  a_r10_no_switch: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !idle) |=> $stable(sel_q) || idle);
endmodule

// File: tb/dma4_engine_tb.sv
module dma4_engine_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        cfg_we = 0;
  logic [1:0]  cfg_ch = 0, cfg_sel = 0, rd_ch = 0, rd_sel = 0;
  logic [31:0] cfg_wdata = 0, rd_data;
  logic        hblank_pulse = 0, vblank_pulse = 0;
  logic        mem_req, mem_we, mem_size, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [3:0]  irq;
  logic        stall_mode = 0, tick = 0;

  dma4_engine dut_i (.*);

  function automatic logic [31:0] pattern(input logic [31:0] a);
    logic [31:0] w;
    w = {a[31:2], 2'b00};
    return {w[15:0] ^ 16'h5A3C, w[31:16] + 16'h1234};
  endfunction

  always @(posedge clk) tick <= ~tick;
  assign mem_ack   = mem_req && (!stall_mode || tick);
  assign mem_rdata = pattern(mem_addr);

  int n_chk = 0, n_fail = 0, n_xfer = 0;
  int irq_cnt [4] = '{0, 0, 0, 0};
  int exp_irq [4] = '{0, 0, 0, 0};
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  typedef struct { logic we; logic sz; logic [31:0] addr; } exp_t;
  exp_t q[$];
  logic [31:0] last_rd = 0;

  always @(negedge clk) begin
    if (rst_n && mem_req && mem_ack) begin
      n_xfer++;
      if (q.size() == 0) chk(0, "R12 unexpected access", mem_addr, 0);
      else begin
        exp_t e;
        e = q.pop_front();
        chk(mem_addr == e.addr, "R6 access address", mem_addr, e.addr);
        chk(mem_we == e.we && mem_size == e.sz, "R12 direction/size",
            {30'b0, mem_we, mem_size}, {30'b0, e.we, e.sz});
        if (mem_we) chk(mem_wdata == last_rd, "R12 write data", mem_wdata, last_rd);
        else last_rd = mem_rdata;
      end
    end
  end

  always @(posedge clk) for (int i = 0; i < 4; i++) if (irq[i]) irq_cnt[i]++;

  // bench-side model of the registers
  logic [31:0] b_src [4], b_dst [4], w_src [4], w_dst [4];
  logic [15:0] b_cnt [4];
  logic [9:0]  b_ctrl [4];
  int          w_cnt [4];

  function automatic int units(input int ch);
    if (b_cnt[ch] != 0) return b_cnt[ch];
    return (ch == 3) ? 65536 : 16384;
  endfunction

  function automatic logic [31:0] stepv(input logic [1:0] c, input logic word);
    int u;
    u = word ? 4 : 2;
    if (c == 2'd1) return -u;
    if (c == 2'd2) return 0;
    return u;
  endfunction

  task automatic model_run(input int ch);
    logic word;
    word = b_ctrl[ch][3];
    if (word) begin w_src[ch][1:0] = 0; w_dst[ch][1:0] = 0; end
    for (int k = 0; k < w_cnt[ch]; k++) begin
      q.push_back('{we: 1'b0, sz: word, addr: w_src[ch]});
      q.push_back('{we: 1'b1, sz: word, addr: w_dst[ch]});
      w_src[ch] += stepv(b_ctrl[ch][7:6], word);
      w_dst[ch] += stepv(b_ctrl[ch][9:8], word);
    end
    if (b_ctrl[ch][1]) exp_irq[ch]++;
    if (b_ctrl[ch][2]) begin
      w_cnt[ch] = units(ch);
      if (b_ctrl[ch][9:8] == 2'd3) w_dst[ch] = b_dst[ch];
    end else b_ctrl[ch][0] = 1'b0;
  endtask

  task automatic bwrite(input int ch, input int sel, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_ch = 2'(ch); cfg_sel = 2'(sel); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
    case (sel)
      0: b_src[ch] = d & ~32'h1;
      1: b_dst[ch] = d & ~32'h1;
      2: b_cnt[ch] = d[15:0];
      default: begin
        bit rise;
        rise = d[0] && !b_ctrl[ch][0];
        b_ctrl[ch] = d[9:0];
        if (rise) begin
          w_src[ch] = b_src[ch]; w_dst[ch] = b_dst[ch]; w_cnt[ch] = units(ch);
          if (d[5:4] == 2'd0) model_run(ch);
        end
      end
    endcase
  endtask

  task automatic pulse(input bit vbl);
    for (int ch = 0; ch < 4; ch++)
      if (b_ctrl[ch][0] && b_ctrl[ch][5:4] == (vbl ? 2'd1 : 2'd2)) model_run(ch);
    @(negedge clk);
    if (vbl) vblank_pulse = 1; else hblank_pulse = 1;
    @(negedge clk);
    vblank_pulse = 0; hblank_pulse = 0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (q.size() != 0 || mem_req);
    repeat (3) @(negedge clk);
  endtask

  task automatic rdreg(input int ch, input int sel, output logic [31:0] v);
    rd_ch = 2'(ch); rd_sel = 2'(sel);
    #1 v = rd_data;
  endtask

  task automatic chk_irq(input string tag);
    for (int i = 0; i < 4; i++) chk(irq_cnt[i] == exp_irq[i], tag, irq_cnt[i], exp_irq[i]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", n_chk, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int base;
    for (int i = 0; i < 4; i++) begin
      b_src[i] = 0; b_dst[i] = 0; b_cnt[i] = 0; b_ctrl[i] = 0;
      w_src[i] = 0; w_dst[i] = 0; w_cnt[i] = 0;
    end
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1: reset state
    for (int ch = 0; ch < 4; ch++)
      for (int s = 0; s < 4; s++) begin
        rdreg(ch, s, v);
        chk(v == 0, "R1 register reset", v, 0);
      end
    chk(!mem_req && irq == 0, "R1 outputs idle", {mem_req, irq}, 0);

    // R2/R4/R6/R7/R9: immediate halfword run with stalls
    stall_mode = 1;
    bwrite(1, 0, 32'h0000_1001);
    rdreg(1, 0, v);
    chk(v == 32'h1000, "R2 source bit0 cleared", v, 32'h1000);
    bwrite(1, 1, 32'h0000_8000);
    bwrite(1, 2, 4);
    bwrite(1, 3, 32'h003);
    wait_idle();
    chk_irq("R9 irq after halfword run");
    rdreg(1, 3, v);
    chk(v == 32'h002, "R7 enable cleared", v, 32'h002);

    // R2/R6: word run, unaligned addresses, decrement source, hold destination
    bwrite(2, 0, 32'h0000_2006);
    bwrite(2, 1, 32'h0000_3003);
    rdreg(2, 1, v);
    chk(v == 32'h3002, "R2 destination bit0 cleared", v, 32'h3002);
    bwrite(2, 2, 3);
    bwrite(2, 3, 32'h249);
    wait_idle();
    chk_irq("R9 no irq when disabled");
    rdreg(2, 3, v);
    chk(v == 32'h248, "R7 enable cleared word run", v, 32'h248);

    // R10: two channels armed on horizontal blank
    bwrite(3, 0, 32'h5000); bwrite(3, 1, 32'h6000); bwrite(3, 2, 2); bwrite(3, 3, 32'h023);
    bwrite(1, 0, 32'h7000); bwrite(1, 1, 32'h7800); bwrite(1, 2, 3); bwrite(1, 3, 32'h023);
    chk(!mem_req, "R5 blank channel waits", mem_req, 0);
    pulse(0);
    wait_idle();
    chk_irq("R10 both channels completed");

    // R5/R8/R4: repeat on vertical blank
    bwrite(0, 0, 32'h100); bwrite(0, 1, 32'h200); bwrite(0, 2, 2); bwrite(0, 3, 32'h315);
    bwrite(2, 0, 32'h400); bwrite(2, 1, 32'h500); bwrite(2, 2, 2); bwrite(2, 3, 32'h015);
    base = n_xfer;
    pulse(0);
    repeat (10) @(negedge clk);
    chk(n_xfer == base, "R5 hblank ignored by vblank channels", n_xfer, base);
    pulse(1);
    wait_idle();
    bwrite(0, 0, 32'h900);
    bwrite(0, 3, 32'h315);
    pulse(1);
    wait_idle();
    rdreg(0, 3, v);
    chk(v == 32'h315, "R8 enable kept on repeat", v, 32'h315);
    chk_irq("R9 repeat irq count");

    // R11: special timing never starts
    bwrite(2, 3, 32'h014);
    bwrite(0, 3, 32'h030);
    bwrite(0, 3, 32'h031);
    bwrite(1, 3, 32'h031);
    base = n_xfer;
    pulse(0); pulse(1);
    repeat (20) @(negedge clk);
    chk(n_xfer == base && !mem_req, "R11 special timing idle", n_xfer, base);

    // R3: zero counts
    stall_mode = 0;
    bwrite(0, 3, 32'h000);
    bwrite(0, 0, 32'hA000); bwrite(0, 1, 32'hB000); bwrite(0, 2, 0);
    base = n_xfer;
    bwrite(0, 3, 32'h281);
    wait_idle();
    chk(n_xfer - base == 2 * 16384, "R3 zero count channel 0", n_xfer - base, 2 * 16384);
    bwrite(3, 0, 32'hC000); bwrite(3, 1, 32'hD000); bwrite(3, 2, 0);
    base = n_xfer;
    bwrite(3, 3, 32'h281);
    wait_idle();
    chk(n_xfer - base == 2 * 65536, "R3 zero count channel 3", n_xfer - base, 2 * 65536);
    chk(q.size() == 0, "R12 all expected accesses seen", q.size(), 0);
    chk_irq("R9 final irq count");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule